// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Targeted Invalidation

This block is a small, fully associative translation cache serving one processor core. Each slot maps a virtual page number to a physical frame number. It also stores the address space identifier (ASID) that was current when the mapping was fetched, a write permission, an execute permission and a global flag. A lookup is answered one cycle after it is accepted. The answer is either a hit carrying the frame and permissions, or a miss. A miss starts a request to an external page-table walker and holds it until the walker answers. The returned mapping is then installed, so that a repeated lookup hits.

Because every slot carries its own ASID, switching the current ASID leaves the contents alone. Mappings from several address spaces can therefore be resident at once. Global mappings match under every ASID. System software keeps the cache consistent with the page tables through invalidation commands. The four kinds are: one page in one address space, one page in every address space, a whole address space except its global mappings, and everything. Each invalidation is confirmed by a single-cycle done pulse. An invalidation that arrives while a walk is outstanding is held back until the returned mapping has been written. This way a mapping fetched before the invalidation can never outlive it.

Top module: `asid_tlb`

## Requirements
- R1: A lookup accepted at a clock edge (`lk_valid` and `lk_ready` high) drives `lk_rsp_valid` high for the following cycle. In that cycle exactly one of `lk_hit` and `lk_miss` is high. On a hit, `lk_pfn`, `lk_perm_w` and `lk_perm_x` show the stored mapping. A slot matches when it is valid, its page equals `lk_vpn`, and either its ASID equals `cur_asid` or its global flag is set.
- R2: Changing `cur_asid` removes no slot. A non-global mapping fetched under one ASID misses under another ASID and hits again once that ASID is current again.
- R3: After a miss, `walk_req` stays high, with `walk_vpn` and `walk_asid` holding the missed page and the ASID of the lookup, until a cycle in which `walk_rsp_valid` is high. At that edge the supplied mapping is installed under `walk_asid`. While the walk is outstanding, `lk_ready` is low and lookups are not answered.
- R4: A mapping installed with `walk_global` set hits under every ASID, and an address-space invalidation does not remove it.
- R5: A hit whose lookup has `lk_write` set on a slot without write permission, or `lk_exec` set on a slot without execute permission, raises `lk_fault`, while `lk_hit` and `lk_pfn` are still reported. `lk_fault` is never high without `lk_hit`.
- R6: An invalidation with `inv_kind` = 2'b00 removes the slot whose page equals `inv_vpn` and whose ASID equals `inv_asid`, or which is global. Slots of the same page in other address spaces stay.
- R7: An invalidation with `inv_kind` = 2'b01 removes every non-global slot whose ASID equals `inv_asid`, and nothing else.
- R8: `inv_kind` = 2'b10 clears every slot in one edge. `inv_kind` = 2'b11 removes every slot for page `inv_vpn`, whatever its ASID and global flag.
- R9: When no walk is outstanding, an invalidation accepted at an edge (`inv_valid` and `inv_ready` high) takes effect at that edge. `inv_done` is high for exactly the one following cycle.
- R10: An invalidation accepted while a walk is outstanding is held: `inv_ready` and `lk_ready` go low. It is applied at the edge after the walk response has been installed, and it removes that freshly installed mapping if the mapping matches. `inv_done` pulses in the cycle after that edge.
- R11: An installed mapping goes into the lowest-numbered empty slot. When every slot is occupied, it goes into the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one only on installs into a full cache.
- R12: After reset, no slot is valid, `lk_ready` and `inv_ready` are high, and `lk_rsp_valid`, `walk_req` and `inv_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_asid | input | ASID_W | Address space of the running context |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_write | input | 1 | Access is a store |
| lk_exec | input | 1 | Access is an instruction fetch |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_rsp_valid | output | 1 | Lookup answer present this cycle |
| lk_hit | output | 1 | Answer is a hit |
| lk_miss | output | 1 | Answer is a miss |
| lk_fault | output | 1 | Hit violates the stored permissions |
| lk_pfn | output | PFN_W | Physical frame on a hit |
| lk_perm_w | output | 1 | Stored write permission on a hit |
| lk_perm_x | output | 1 | Stored execute permission on a hit |
| walk_req | output | 1 | Page-table walk requested |
| walk_vpn | output | VPN_W | Page to walk |
| walk_asid | output | ASID_W | Address space of the walk |
| walk_rsp_valid | input | 1 | Walker supplies the mapping |
| walk_pfn | input | PFN_W | Supplied frame |
| walk_perm_w | input | 1 | Supplied write permission |
| walk_perm_x | input | 1 | Supplied execute permission |
| walk_global | input | 1 | Supplied mapping is global |
| inv_valid | input | 1 | Invalidation request |
| inv_kind | input | 2 | 00 page+ASID, 01 ASID, 10 all, 11 page in any ASID |
| inv_vpn | input | VPN_W | Page named by the invalidation |
| inv_asid | input | ASID_W | ASID named by the invalidation |
| inv_ready | output | 1 | Invalidation can be accepted |
| inv_done | output | 1 | One-cycle pulse after the invalidation took effect |

## Verification
Lookup answers are due in the cycle right after the accepting edge. Walk requests rise in that same cycle. A direct invalidation's done pulse is due in the cycle after its accepting edge and must be gone one cycle later. A held invalidation's pulse is due two edges after the walk response: the install edge, then the apply edge. The bench drives every input on the falling edge and reads outputs on the next falling edge, after exactly the number of rising edges each result needs. The deferred case is checked at both the install cycle and the apply cycle. The effect of every invalidation and replacement is observed only through later lookups at the ports.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      INV_PAGE     = 2'b00,
      INV_SPACE    = 2'b01,
      INV_ALL      = 2'b10,
      INV_PAGE_ANY = 2'b11
   } inv_kind_e;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic [ENTRIES-1:0]             valid_i,
   input  logic [ENTRIES-1:0]             glob_i,
   input  logic [ENTRIES-1:0]             pw_i,
   input  logic [ENTRIES-1:0]             px_i,
   input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_i,
   input  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_i,
   input  logic [ENTRIES-1:0][ASID_W-1:0] asid_i,
   input  logic [VPN_W-1:0]               key_vpn_i,
   input  logic [ASID_W-1:0]              key_asid_i,
   output logic                           hit_o,
   output logic [PFN_W-1:0]               pfn_o,
   output logic                           pw_o,
   output logic                           px_o
);

   logic [ENTRIES-1:0] hit_vec;

   // one comparator per slot
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = valid_i[g] && (vpn_i[g] == key_vpn_i) &&
                          (glob_i[g] || (asid_i[g] == key_asid_i));
   end

   // and-or select; at most one slot matches because installs follow misses
   always_comb begin
      hit_o = |hit_vec;
      pfn_o = '0;
      pw_o  = 1'b0;
      px_o  = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) begin
            pfn_o = pfn_o | pfn_i[i];
            pw_o  = pw_o | pw_i[i];
            px_o  = px_o | px_i[i];
         end
      end
   end

endmodule

// File: rtl/tlb_inv_sel.sv
module tlb_inv_sel
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic [ENTRIES-1:0]             valid_i,
   input  logic [ENTRIES-1:0]             glob_i,
   input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_i,
   input  logic [ENTRIES-1:0][ASID_W-1:0] asid_i,
   input  inv_kind_e                      kind_i,
   input  logic [VPN_W-1:0]               vpn_key_i,
   input  logic [ASID_W-1:0]              asid_key_i,
   output logic [ENTRIES-1:0]             kill_o
);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_kill
      logic page_eq;
      logic space_eq;
      assign page_eq  = (vpn_i[g] == vpn_key_i);
      assign space_eq = (asid_i[g] == asid_key_i);
      always_comb begin
         unique case (kind_i)
            INV_PAGE:     kill_o[g] = valid_i[g] && page_eq && (space_eq || glob_i[g]);
            INV_SPACE:    kill_o[g] = valid_i[g] && space_eq && !glob_i[g];
            INV_ALL:      kill_o[g] = valid_i[g];
            INV_PAGE_ANY: kill_o[g] = valid_i[g] && page_eq;
            default:      kill_o[g] = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid_i,
   input  logic               advance_i,
   output logic [IDX_W-1:0]   victim_o
);

   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] rr_next;
   logic [IDX_W-1:0] first_free;
   logic             any_free;

   always_comb begin
      first_free = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_i[i]) first_free = IDX_W'(i);
      end
   end

   assign any_free = ~&valid_i;
   assign victim_o = any_free ? first_free : rr_q;

   // pointer wrap: free for a power-of-two depth, compared otherwise
   if ((1 << IDX_W) == ENTRIES) begin : g_wrap_pow2
      assign rr_next = rr_q + 1'b1;
   end else begin : g_wrap_cmp
      assign rr_next = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     rr_q <= '0;
      else if (advance_i && !any_free) rr_q <= rr_next;
   end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic              lk_write,
   input  logic              lk_exec,
   output logic              lk_ready,
   output logic              lk_rsp_valid,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic              lk_fault,
   output logic [PFN_W-1:0]  lk_pfn,
   output logic              lk_perm_w,
   output logic              lk_perm_x,
   output logic              walk_req,
   output logic [VPN_W-1:0]  walk_vpn,
   output logic [ASID_W-1:0] walk_asid,
   input  logic              walk_rsp_valid,
   input  logic [PFN_W-1:0]  walk_pfn,
   input  logic              walk_perm_w,
   input  logic              walk_perm_x,
   input  logic              walk_global,
   input  logic              inv_valid,
   input  logic [1:0]        inv_kind,
   input  logic [VPN_W-1:0]  inv_vpn,
   input  logic [ASID_W-1:0] inv_asid,
   output logic              inv_ready,
   output logic              inv_done
);

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_entries
      $error("asid_tlb: ENTRIES must lie in 2..64");
   end
   if (VPN_W < 1 || PFN_W < 1 || ASID_W < 1) begin : g_bad_width
      $error("asid_tlb: widths must be positive");
   end

   // slot storage
   logic [ENTRIES-1:0]             valid_q;
   logic [ENTRIES-1:0]             glob_q;
   logic [ENTRIES-1:0]             pw_q;
   logic [ENTRIES-1:0]             px_q;
   logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
   logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
   logic [ENTRIES-1:0][ASID_W-1:0] asid_q;

   // outstanding walk
   logic              pending_q;
   logic [VPN_W-1:0]  wvpn_q;
   logic [ASID_W-1:0] wasid_q;

   // invalidation held behind a walk
   logic              held_q;
   inv_kind_e         hkind_q;
   logic [VPN_W-1:0]  hvpn_q;
   logic [ASID_W-1:0] hasid_q;

   logic              lk_fire, fill_fire, inv_take;
   logic              direct_apply, held_apply, apply_fire;
   inv_kind_e         a_kind;
   logic [VPN_W-1:0]  a_vpn;
   logic [ASID_W-1:0] a_asid;
   logic              m_hit, m_pw, m_px;
   logic [PFN_W-1:0]  m_pfn;
   logic [ENTRIES-1:0] kill;
   logic [IDX_W-1:0]  victim;
   logic              perm_bad;

   assign lk_ready  = !pending_q && !held_q;
   assign inv_ready = !held_q;
   assign walk_req  = pending_q;
   assign walk_vpn  = wvpn_q;
   assign walk_asid = wasid_q;

   assign lk_fire      = lk_valid && lk_ready;
   assign fill_fire    = pending_q && walk_rsp_valid;
   assign inv_take     = inv_valid && inv_ready;
   assign direct_apply = inv_take && !pending_q;
   assign held_apply   = held_q && !pending_q;
   assign apply_fire   = direct_apply || held_apply;

   assign a_kind = held_apply ? hkind_q : inv_kind_e'(inv_kind);
   assign a_vpn  = held_apply ? hvpn_q  : inv_vpn;
   assign a_asid = held_apply ? hasid_q : inv_asid;

   tlb_match #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)
   ) u_match (
      .valid_i(valid_q), .glob_i(glob_q), .pw_i(pw_q), .px_i(px_q),
      .vpn_i(vpn_q), .pfn_i(pfn_q), .asid_i(asid_q),
      .key_vpn_i(lk_vpn), .key_asid_i(cur_asid),
      .hit_o(m_hit), .pfn_o(m_pfn), .pw_o(m_pw), .px_o(m_px)
   );

   tlb_inv_sel #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)
   ) u_inv (
      .valid_i(valid_q), .glob_i(glob_q), .vpn_i(vpn_q), .asid_i(asid_q),
      .kind_i(a_kind), .vpn_key_i(a_vpn), .asid_key_i(a_asid),
      .kill_o(kill)
   );

   tlb_victim #(
      .ENTRIES(ENTRIES)
   ) u_victim (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_q),
      .advance_i(fill_fire), .victim_o(victim)
   );

   // valid bits: invalidate and install never share an edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (apply_fire) begin
         valid_q <= valid_q & ~kill;
      end else if (fill_fire) begin
         valid_q[victim] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_fire) begin
         vpn_q[victim]  <= wvpn_q;
         asid_q[victim] <= wasid_q;
         pfn_q[victim]  <= walk_pfn;
         pw_q[victim]   <= walk_perm_w;
         px_q[victim]   <= walk_perm_x;
         glob_q[victim] <= walk_global;
      end
   end

   assign perm_bad = (lk_write && !m_pw) || (lk_exec && !m_px);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lk_rsp_valid <= 1'b0;
         lk_hit       <= 1'b0;
         lk_miss      <= 1'b0;
         lk_fault     <= 1'b0;
         lk_pfn       <= '0;
         lk_perm_w    <= 1'b0;
         lk_perm_x    <= 1'b0;
      end else begin
         lk_rsp_valid <= lk_fire;
         lk_hit       <= lk_fire && m_hit;
         lk_miss      <= lk_fire && !m_hit;
         lk_fault     <= lk_fire && m_hit && perm_bad;
         lk_pfn       <= (lk_fire && m_hit) ? m_pfn : '0;
         lk_perm_w    <= lk_fire && m_hit && m_pw;
         lk_perm_x    <= lk_fire && m_hit && m_px;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
         wvpn_q    <= '0;
         wasid_q   <= '0;
      end else if (lk_fire && !m_hit) begin
         pending_q <= 1'b1;
         wvpn_q    <= lk_vpn;
         wasid_q   <= cur_asid;
      end else if (fill_fire) begin
         pending_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q  <= 1'b0;
         hkind_q <= INV_PAGE;
         hvpn_q  <= '0;
         hasid_q <= '0;
      end else if (inv_take && pending_q) begin
         held_q  <= 1'b1;
         hkind_q <= inv_kind_e'(inv_kind);
         hvpn_q  <= inv_vpn;
         hasid_q <= inv_asid;
      end else if (held_apply) begin
         held_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) inv_done <= 1'b0;
      else        inv_done <= apply_fire;
   end

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
   parameter int ENTRIES = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_rsp_valid,
   input logic               lk_hit,
   input logic               lk_miss,
   input logic               lk_fault,
   input logic               walk_req,
   input logic               walk_rsp_valid,
   input logic [ENTRIES-1:0] valid_q,
   input logic               apply_fire,
   input logic [1:0]         kind
);

   // R1: an answer is exactly one of hit or miss
   p_one_answer_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_rsp_valid |-> ($countones({lk_hit, lk_miss}) == 1));

   // R1: no answer flags outside an answer cycle
   p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_rsp_valid |-> (!lk_hit && !lk_miss));

   // R5: a fault comes only with a hit
   p_fault_on_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault |-> lk_hit);

   // R3: a miss answer has a walk request beside it
   p_miss_walks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_rsp_valid && lk_miss) |-> walk_req);

   // R3: the walk request holds until answered
   p_walk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req && !walk_rsp_valid) |=> walk_req);

   // R2: slots vanish only through an invalidation
   p_no_silent_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !apply_fire |=> (($past(valid_q) & ~valid_q) == '0));

   // R8: flush-all leaves nothing valid
   p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (apply_fire && kind == 2'b10) |=> (valid_q == '0));

endmodule

bind asid_tlb asid_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit), .lk_miss(lk_miss),
   .lk_fault(lk_fault), .walk_req(walk_req), .walk_rsp_valid(walk_rsp_valid),
   .valid_q(valid_q), .apply_fire(apply_fire), .kind(a_kind)
);

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;

   localparam int VPN_W  = 20;
   localparam int PFN_W  = 20;
   localparam int ASID_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [ASID_W-1:0] cur_asid = '0;
   logic lk_valid = 1'b0;
   logic [VPN_W-1:0] lk_vpn = '0;
   logic lk_write = 1'b0, lk_exec = 1'b0;
   logic lk_ready, lk_rsp_valid, lk_hit, lk_miss, lk_fault, lk_perm_w, lk_perm_x;
   logic [PFN_W-1:0] lk_pfn;
   logic walk_req;
   logic [VPN_W-1:0] walk_vpn;
   logic [ASID_W-1:0] walk_asid;
   logic walk_rsp_valid = 1'b0;
   logic [PFN_W-1:0] walk_pfn = '0;
   logic walk_perm_w = 1'b0, walk_perm_x = 1'b0, walk_global = 1'b0;
   logic inv_valid = 1'b0;
   logic [1:0] inv_kind = 2'b00;
   logic [VPN_W-1:0] inv_vpn = '0;
   logic [ASID_W-1:0] inv_asid = '0;
   logic inv_ready, inv_done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   asid_tlb u_dut (
      .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_write(lk_write), .lk_exec(lk_exec),
      .lk_ready(lk_ready), .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit),
      .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_pfn(lk_pfn),
      .lk_perm_w(lk_perm_w), .lk_perm_x(lk_perm_x),
      .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_asid(walk_asid),
      .walk_rsp_valid(walk_rsp_valid), .walk_pfn(walk_pfn),
      .walk_perm_w(walk_perm_w), .walk_perm_x(walk_perm_x), .walk_global(walk_global),
      .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_vpn(inv_vpn),
      .inv_asid(inv_asid), .inv_ready(inv_ready), .inv_done(inv_done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // drive on the falling edge; result read one falling edge later
   task automatic lookup(input logic [VPN_W-1:0] v, input bit wr, input bit ex);
      lk_valid = 1'b1; lk_vpn = v; lk_write = wr; lk_exec = ex;
      @(posedge clk); @(negedge clk);
      lk_valid = 1'b0; lk_write = 1'b0; lk_exec = 1'b0;
   endtask

   task automatic serve(input logic [PFN_W-1:0] p, input bit w, input bit x, input bit g);
      walk_rsp_valid = 1'b1; walk_pfn = p;
      walk_perm_w = w; walk_perm_x = x; walk_global = g;
      @(posedge clk); @(negedge clk);
      walk_rsp_valid = 1'b0; walk_global = 1'b0;
   endtask

   task automatic expect_hit(input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p,
                             input string req);
      lookup(v, 1'b0, 1'b0);
      chk(lk_rsp_valid && lk_hit, req, "hit", 32'(lk_hit), 32'd1);
      chk(lk_pfn == p, req, "frame", 32'(lk_pfn), 32'(p));
   endtask

   // miss, check walk fields, then install the mapping
   task automatic miss_fill(input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p,
                            input bit w, input bit x, input bit g, input string req);
      lookup(v, 1'b0, 1'b0);
      chk(lk_rsp_valid && lk_miss, req, "miss", 32'(lk_miss), 32'd1);
      chk(walk_req && walk_vpn == v && walk_asid == cur_asid, req, "walk vpn",
          32'(walk_vpn), 32'(v));
      serve(p, w, x, g);
   endtask

   // direct invalidation with done-pulse check (R9)
   task automatic do_inv(input logic [1:0] k, input logic [VPN_W-1:0] v,
                         input logic [ASID_W-1:0] a);
      inv_valid = 1'b1; inv_kind = k; inv_vpn = v; inv_asid = a;
      @(posedge clk); @(negedge clk);
      inv_valid = 1'b0;
      chk(inv_done == 1'b1, "R9", "done pulse", 32'(inv_done), 32'd1);
      @(negedge clk);
      chk(inv_done == 1'b0, "R9", "done one cycle", 32'(inv_done), 32'd0);
   endtask

   task automatic t_reset;
      chk(lk_ready && inv_ready, "R12", "ready after reset", 32'({lk_ready, inv_ready}), 32'd3);
      chk(!lk_rsp_valid && !walk_req && !inv_done, "R12", "quiet after reset",
          32'({lk_rsp_valid, walk_req, inv_done}), 32'd0);
      cur_asid = 8'd9;
      lookup(20'h00777, 1'b0, 1'b0);
      chk(lk_miss, "R12", "empty after reset", 32'(lk_miss), 32'd1);
      serve(20'h1, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_basic;
      cur_asid = 8'd1;
      lookup(20'h00100, 1'b0, 1'b0);
      chk(lk_miss && !lk_hit, "R1", "first access misses", 32'(lk_miss), 32'd1);
      chk(walk_req && walk_vpn == 20'h00100 && walk_asid == 8'd1, "R3", "walk fields",
          32'(walk_vpn), 32'h100);
      chk(!lk_ready, "R3", "lookup blocked during walk", 32'(lk_ready), 32'd0);
      lookup(20'h00100, 1'b0, 1'b0);
      chk(!lk_rsp_valid, "R3", "lookup ignored while walking", 32'(lk_rsp_valid), 32'd0);
      chk(walk_req, "R3", "walk held", 32'(walk_req), 32'd1);
      serve(20'h0ABC, 1'b1, 1'b0, 1'b0);
      chk(!walk_req && lk_ready, "R3", "walk closed", 32'(walk_req), 32'd0);
      lookup(20'h00100, 1'b0, 1'b0);
      chk(lk_hit && lk_pfn == 20'h0ABC, "R1", "refill hits", 32'(lk_pfn), 32'h0ABC);
      chk(lk_perm_w && !lk_perm_x, "R1", "perms", 32'({lk_perm_w, lk_perm_x}), 32'd2);
   endtask

   task automatic t_prot;
      lookup(20'h00100, 1'b1, 1'b0);
      chk(lk_hit && !lk_fault, "R5", "allowed write", 32'(lk_fault), 32'd0);
      lookup(20'h00100, 1'b0, 1'b1);
      chk(lk_hit && lk_fault && lk_pfn == 20'h0ABC, "R5", "exec fault",
          32'({lk_hit, lk_fault}), 32'd3);
   endtask

   task automatic t_space;
      cur_asid = 8'd2;
      miss_fill(20'h00100, 20'h0222, 1'b0, 1'b1, 1'b0, "R2");
      cur_asid = 8'd1;
      expect_hit(20'h00100, 20'h0ABC, "R2");
      cur_asid = 8'd2;
      expect_hit(20'h00100, 20'h0222, "R2");
   endtask

   task automatic t_global;
      cur_asid = 8'd1;
      miss_fill(20'h00200, 20'h0055, 1'b0, 1'b0, 1'b1, "R4");
      cur_asid = 8'd3;
      expect_hit(20'h00200, 20'h0055, "R4");
      do_inv(2'b01, 20'h0, 8'd1);
      expect_hit(20'h00200, 20'h0055, "R4");
      cur_asid = 8'd1;
      miss_fill(20'h00100, 20'h0ABD, 1'b1, 1'b0, 1'b0, "R7");
      cur_asid = 8'd2;
      expect_hit(20'h00100, 20'h0222, "R7");
   endtask

   task automatic t_page;
      do_inv(2'b00, 20'h00100, 8'd2);
      cur_asid = 8'd1;
      expect_hit(20'h00100, 20'h0ABD, "R6");
      cur_asid = 8'd2;
      miss_fill(20'h00100, 20'h0223, 1'b0, 1'b0, 1'b0, "R6");
      do_inv(2'b00, 20'h00200, 8'd7);
      cur_asid = 8'd3;
      miss_fill(20'h00200, 20'h0056, 1'b0, 1'b0, 1'b1, "R6");
   endtask

   task automatic t_any_flush;
      cur_asid = 8'd4;
      miss_fill(20'h00300, 20'h0444, 1'b0, 1'b0, 1'b0, "R8");
      cur_asid = 8'd5;
      miss_fill(20'h00300, 20'h0555, 1'b0, 1'b0, 1'b0, "R8");
      do_inv(2'b11, 20'h00300, 8'd0);
      cur_asid = 8'd4;
      miss_fill(20'h00300, 20'h0446, 1'b0, 1'b0, 1'b0, "R8");
      cur_asid = 8'd5;
      miss_fill(20'h00300, 20'h0556, 1'b0, 1'b0, 1'b0, "R8");
      do_inv(2'b10, 20'h0, 8'd0);
      cur_asid = 8'd3;
      miss_fill(20'h00200, 20'h0057, 1'b0, 1'b0, 1'b1, "R8");
   endtask

   task automatic t_defer;
      do_inv(2'b10, 20'h0, 8'd0);
      cur_asid = 8'd1;
      lookup(20'h00400, 1'b0, 1'b0);
      chk(lk_miss && walk_req, "R10", "walk open", 32'(walk_req), 32'd1);
      inv_valid = 1'b1; inv_kind = 2'b00; inv_vpn = 20'h00400; inv_asid = 8'd1;
      @(posedge clk); @(negedge clk);
      inv_valid = 1'b0;
      chk(!inv_done && !inv_ready, "R10", "held, no done",
          32'({inv_done, inv_ready}), 32'd0);
      serve(20'h0999, 1'b1, 1'b1, 1'b0);
      chk(!inv_done && !lk_ready, "R10", "install edge no done",
          32'({inv_done, lk_ready}), 32'd0);
      @(negedge clk);
      chk(inv_done && lk_ready && inv_ready, "R10", "apply edge done",
          32'({inv_done, lk_ready, inv_ready}), 32'd7);
      @(negedge clk);
      chk(!inv_done, "R9", "held done one cycle", 32'(inv_done), 32'd0);
      miss_fill(20'h00400, 20'h099A, 1'b0, 1'b0, 1'b0, "R10");
   endtask

   task automatic t_replace;
      do_inv(2'b10, 20'h0, 8'd0);
      cur_asid = 8'd1;
      for (int i = 0; i < 16; i++) begin
         lookup(20'h01000 + 20'(i), 1'b0, 1'b0);
         serve(20'h02000 + 20'(i), 1'b0, 1'b0, 1'b0);
      end
      lookup(20'h01010, 1'b0, 1'b0);
      serve(20'h03010, 1'b0, 1'b0, 1'b0);       // full: pointer slot 0
      expect_hit(20'h01001, 20'h02001, "R11");
      expect_hit(20'h01010, 20'h03010, "R11");
      do_inv(2'b00, 20'h01007, 8'd1);
      lookup(20'h01020, 1'b0, 1'b0);
      serve(20'h03020, 1'b0, 1'b0, 1'b0);       // free slot 7 preferred
      expect_hit(20'h01001, 20'h02001, "R11");
      expect_hit(20'h01020, 20'h03020, "R11");
      lookup(20'h01021, 1'b0, 1'b0);
      serve(20'h03021, 1'b0, 1'b0, 1'b0);       // pointer slot 1
      expect_hit(20'h01002, 20'h02002, "R11");
      lookup(20'h01001, 1'b0, 1'b0);
      chk(lk_miss, "R11", "round-robin victim evicted", 32'(lk_miss), 32'd1);
      serve(20'h1, 1'b0, 1'b0, 1'b0);
      lookup(20'h01000, 1'b0, 1'b0);
      chk(lk_miss, "R11", "first victim evicted", 32'(lk_miss), 32'd1);
      serve(20'h1, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_basic;
      t_prot;
      t_space;
      t_global;
      t_page;
      t_any_flush;
      t_defer;
      t_replace;
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule